// File: doc/BRIEF.md
# SCSI Synchronous Offset Flow Controller

This block limits how far a synchronous SCSI data phase may run ahead of its handshake. It holds a programmed offset limit and a count of outstanding bytes. A byte strobe leaves the block only while the count is below the limit. Each issued strobe raises the count, and each rising edge of the returning acknowledge lowers it. When the limit is zero, the block falls back to fully interlocked transfers: one byte, then a complete handshake, then the next byte.

Software reaches the block through one register address, and the direction of the access selects the register. A write loads the offset limit. A read returns a status byte that packs the 3-bit sequence state supplied by the sequencer with the FIFO byte count supplied by the data FIFO. In test mode, one status bit instead shows whether the window is still open. A newly written limit is not applied straight away. It waits until no bytes are outstanding, so a window that is in use is never shrunk below its current occupancy. An acknowledge that arrives when nothing is outstanding is dropped and latches a sticky protocol-error flag.

Top module: `scsi_offset_throttle`

## Requirements
- R1: After a hard reset (rst_n low at a clock edge), the applied limit, the pending limit, the outstanding count and the error flag are all zero. A read of address 7 with zero sequence and FIFO inputs returns 0x00.
- R2: A write (reg_wr high) to address 7 stores reg_wdata[3:0] as the pending limit and ignores bits 7:4. A write to any other address changes nothing.
- R3: With an applied limit L > 0, strb_ok is high exactly when the outstanding count is below L, and strb_out equals xfer_req AND strb_ok.
- R4: With an applied limit of 0, strb_ok is high only when the outstanding count is 0. At most one byte is outstanding.
- R5: The outstanding count rises by one for each issued strobe and falls by one for each rising edge of ack_in while it is nonzero. An issued strobe and an acknowledge edge in the same cycle leave it unchanged.
- R6: The pending limit is copied into the applied limit only at a clock edge where the outstanding count is 0. The copy takes effect one cycle after that edge.
- R7: An ack_in rising edge while the count is 0 leaves the count unchanged and sets proto_err. proto_err then stays high until a hard or soft reset.
- R8: A read (reg_rd high) of address 7 outside test mode returns seq_state in bits 7:5 and fifo_count in bits 4:0. reg_rdata is 0x00 when reg_rd is low or the address is not 7.
- R9: In test mode, a read of address 7 returns strb_ok in bit 5, seq_state[2:1] in bits 7:6, and fifo_count in bits 4:0.
- R10: A soft reset (soft_rst high at a clock edge) clears the pending limit, the applied limit, the count and proto_err.
- R11: strb_ok is combinational from the count and the applied limit. A strobe may be issued in the first cycle after an acknowledge edge lowers the count below the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hard reset |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| test_mode | input | 1 | Selects the test-mode status layout |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| seq_state | input | 3 | Sequence state from the phase sequencer |
| fifo_count | input | 5 | Byte count from the data FIFO |
| xfer_req | input | 1 | Transfer path wants to strobe a byte |
| ack_in | input | 1 | Returning acknowledge (or request when receiving), level |
| strb_ok | output | 1 | Window open: a strobe is permitted this cycle |
| strb_out | output | 1 | Strobe issued this cycle |
| pend_cnt | output | 4 | Outstanding byte count |
| proto_err | output | 1 | Sticky flag for an acknowledge with nothing outstanding |

## Verification
Two functions of this block can land in the same cycle: a strobe issued while the window is open, and an acknowledge edge that retires an older byte. The bench provokes this by raising xfer_req and ack_in together while the count sits below the limit. The count must stay the same. A second overlap is a limit write made while bytes are outstanding. The bench checks that the old window still governs until the acknowledges have drained the count to zero, and that the new window applies two cycles later.

// File: rtl/scsi_ofs_pkg.sv
// Package: shared widths and status-byte packing for the offset controller.
// Assumes an 8-bit register bus with a 3-bit sequence state and a 5-bit FIFO count.
package scsi_ofs_pkg;
    localparam int DATA_W   = 8;
    localparam int SEQ_W    = 3;
    localparam int FIFO_W   = 5;
    localparam int OPEN_BIT = 5;

    // Build the status byte in either the normal or the test-mode layout.
    function automatic logic [DATA_W-1:0] pack_status(
        input logic [SEQ_W-1:0]  seq,
        input logic [FIFO_W-1:0] fifo,
        input logic              tmode,
        input logic              win_open
    );
        logic [DATA_W-1:0] b;
        b = {seq, fifo};
        if (tmode) begin
            b[OPEN_BIT] = win_open;
        end
        return b;
    endfunction
endpackage

// File: rtl/ofs_limit_reg.sv
// Module: ofs_limit_reg
// Holds the offset limit written by software (pending). It copies the limit into
// the applied copy only while no bytes are outstanding.
// Assumes: synchronous active-low hard reset. soft_rst clears both copies.
module ofs_limit_reg #(
    parameter int OFS_W    = 4,
    parameter int ADDR_W   = 4,
    parameter int OFS_ADDR = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              cnt_zero,
    output logic [OFS_W-1:0]  act_lim
);
    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(OFS_ADDR);

    logic [OFS_W-1:0] pend_lim;
    logic             wr_hit;

    // Decode a write to the offset register.
    always_comb wr_hit = reg_wr && (reg_addr == HIT_ADDR);

    // Capture the low bits of a write as the pending limit.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            pend_lim <= '0;
        end else if (wr_hit) begin
            pend_lim <= reg_wdata[OFS_W-1:0];
        end
    end

    // Apply the pending limit only when the window is empty.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            act_lim <= '0;
        end else if (cnt_zero) begin
            act_lim <= pend_lim;
        end
    end

    p_wr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !soft_rst) |=> (pend_lim == $past(reg_wdata[OFS_W-1:0])));

    p_wr_other_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_hit && !soft_rst) |=> $stable(pend_lim));

    p_hold_lim_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_zero && !soft_rst) |=> $stable(act_lim));

    p_soft_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (act_lim == '0 && pend_lim == '0));
endmodule

// File: rtl/ofs_window_ctr.sv
// Module: ofs_window_ctr
// Counts outstanding bytes against the applied limit and gates the strobe path.
// A limit of zero acts as a window of one, which gives interlocked transfers.
// Assumes: ack_in is a level that is synchronous to clk. Only its rising edge counts.
module ofs_window_ctr #(
    parameter int OFS_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic [OFS_W-1:0] act_lim,
    input  logic             xfer_req,
    input  logic             ack_in,
    output logic             permit,
    output logic             strobe,
    output logic [OFS_W-1:0] cnt,
    output logic             cnt_zero,
    output logic             proto_err
);
    logic [OFS_W-1:0] eff_lim;
    logic             ack_q;
    logic             ack_rise;
    logic             ack_take;
    logic             ack_bad;

    // A zero limit behaves as a one-byte window.
    always_comb eff_lim = (act_lim == '0) ? OFS_W'(1) : act_lim;

    // The window is open while the outstanding count is below the limit.
    always_comb begin
        permit   = (cnt < eff_lim);
        strobe   = xfer_req && permit;
        cnt_zero = (cnt == '0);
    end

    // Track the acknowledge level to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
        end else begin
            ack_q <= ack_in;
        end
    end

    // Sort each acknowledge edge into a retire or a protocol error.
    always_comb begin
        ack_rise = ack_in && !ack_q;
        ack_take = ack_rise && !cnt_zero;
        ack_bad  = ack_rise && cnt_zero;
    end

    // Count issued strobes up and accepted acknowledges down.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            cnt <= '0;
        end else if (strobe && !ack_take) begin
            cnt <= cnt + 1'b1;
        end else if (ack_take && !strobe) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Latch a sticky error on an acknowledge with nothing outstanding.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            proto_err <= 1'b0;
        end else if (ack_bad) begin
            proto_err <= 1'b1;
        end
    end

    p_cnt_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= eff_lim);

    p_async_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (act_lim == '0 && !cnt_zero) |-> !permit);

    p_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !ack_take && !soft_rst) |=> (cnt == $past(cnt) + 1'b1));

    p_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && ack_take && !soft_rst) |=> $stable(cnt));

    p_err_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_bad && !soft_rst) |=> proto_err);

    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (proto_err && !soft_rst) |=> proto_err);

    p_soft_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (cnt == '0 && !proto_err));
endmodule

// File: rtl/ofs_status_rd.sv
// Module: ofs_status_rd
// Read side of the shared register address: returns the status byte.
// Assumes: the read path is combinational and returns zero when not selected.
module ofs_status_rd #(
    parameter int ADDR_W   = 4,
    parameter int OFS_ADDR = 7
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                reg_rd,
    input  logic [ADDR_W-1:0]                   reg_addr,
    input  logic                                test_mode,
    input  logic [scsi_ofs_pkg::SEQ_W-1:0]      seq_state,
    input  logic [scsi_ofs_pkg::FIFO_W-1:0]     fifo_count,
    input  logic                                win_open,
    output logic [scsi_ofs_pkg::DATA_W-1:0]     reg_rdata
);
    import scsi_ofs_pkg::*;

    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(OFS_ADDR);

    logic rd_hit;

    // Select the status byte on a read of the shared address.
    always_comb begin
        rd_hit    = reg_rd && (reg_addr == HIT_ADDR);
        reg_rdata = rd_hit ? pack_status(seq_state, fifo_count, test_mode, win_open)
                           : '0;
    end

    p_rd_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |-> (reg_rdata == '0));

    p_tm_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && test_mode) |-> (reg_rdata[OPEN_BIT] == win_open));

    p_fifo_field_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |-> (reg_rdata[FIFO_W-1:0] == fifo_count));
endmodule

// File: rtl/scsi_offset_throttle.sv
// Module: scsi_offset_throttle (top)
// Synchronous-offset flow controller. It gates byte strobes against a programmed
// window of outstanding handshakes and serves a write-limit / read-status register.
// Assumes: every input is synchronous to clk. Bus drivers and the FIFO are outside.
module scsi_offset_throttle #(
    parameter int OFS_W    = 4,
    parameter int ADDR_W   = 4,
    parameter int OFS_ADDR = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              test_mode,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [2:0]        seq_state,
    input  logic [4:0]        fifo_count,
    input  logic              xfer_req,
    input  logic              ack_in,
    output logic              strb_ok,
    output logic              strb_out,
    output logic [OFS_W-1:0]  pend_cnt,
    output logic              proto_err
);
    logic [OFS_W-1:0] act_lim;
    logic             cnt_zero;

    ofs_limit_reg #(
        .OFS_W    (OFS_W),
        .ADDR_W   (ADDR_W),
        .OFS_ADDR (OFS_ADDR)
    ) u_lim (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .cnt_zero  (cnt_zero),
        .act_lim   (act_lim)
    );

    ofs_window_ctr #(
        .OFS_W (OFS_W)
    ) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .act_lim   (act_lim),
        .xfer_req  (xfer_req),
        .ack_in    (ack_in),
        .permit    (strb_ok),
        .strobe    (strb_out),
        .cnt       (pend_cnt),
        .cnt_zero  (cnt_zero),
        .proto_err (proto_err)
    );

    ofs_status_rd #(
        .ADDR_W   (ADDR_W),
        .OFS_ADDR (OFS_ADDR)
    ) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .test_mode  (test_mode),
        .seq_state  (seq_state),
        .fifo_count (fifo_count),
        .win_open   (strb_ok),
        .reg_rdata  (reg_rdata)
    );

    p_strobe_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        strb_out |-> (strb_ok && xfer_req));

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (pend_cnt == '0 && !proto_err));
endmodule

// File: tb/tb_scsi_offset_throttle.sv
// Scoreboard bench: the driver applies stimulus on each falling edge. It computes
// the expected outputs from a reference model built from the requirements and
// queues them. A monitor pops and compares them mid-phase.
module tb_scsi_offset_throttle;
    logic       clk = 1'b1;
    logic       rst_n = 1'b0, soft_rst = 1'b0, test_mode = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [2:0] seq_state = '0;
    logic [4:0] fifo_count = '0;
    logic       xfer_req = 1'b0, ack_in = 1'b0;
    logic       strb_ok, strb_out, proto_err;
    logic [3:0] pend_cnt;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    scsi_offset_throttle dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .test_mode(test_mode),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .seq_state(seq_state), .fifo_count(fifo_count),
        .xfer_req(xfer_req), .ack_in(ack_in), .strb_ok(strb_ok), .strb_out(strb_out),
        .pend_cnt(pend_cnt), .proto_err(proto_err)
    );

    // Reference model state
    logic [3:0] m_pend = '0, m_act = '0, m_cnt = '0;
    logic       m_err = 1'b0, m_ackq = 1'b0;

    // Expected item queues
    logic [15:0] exp_q[$];
    string       tag_q[$];

    task automatic step(input logic rs, input logic sr, input logic tm,
                        input logic rq, input logic ak, input logic wr,
                        input logic rd, input logic [3:0] ad, input logic [7:0] wd,
                        input logic [2:0] sq, input logic [4:0] ff, input string tag);
        logic [3:0] eff;
        logic       perm, iss, rise;
        logic [7:0] rdv;
        @(negedge clk);
        rst_n = rs; soft_rst = sr; test_mode = tm; xfer_req = rq; ack_in = ak;
        reg_wr = wr; reg_rd = rd; reg_addr = ad; reg_wdata = wd;
        seq_state = sq; fifo_count = ff;
        eff  = (m_act == 4'd0) ? 4'd1 : m_act;
        perm = (m_cnt < eff);
        iss  = rq && perm;
        rise = ak && !m_ackq;
        if (rd && ad == 4'd7) rdv = tm ? {sq[2:1], perm, ff} : {sq, ff};
        else                  rdv = 8'h00;
        exp_q.push_back({rdv, m_cnt, m_err, iss, perm, 1'b0});
        tag_q.push_back(tag);
        if (!rs) begin
            m_pend = '0; m_act = '0; m_cnt = '0; m_err = 1'b0; m_ackq = 1'b0;
        end else begin
            m_ackq = ak;
            if (sr) begin
                m_pend = '0; m_act = '0; m_cnt = '0; m_err = 1'b0;
            end else begin
                if (m_cnt == 4'd0) m_act = m_pend;
                if (wr && ad == 4'd7) m_pend = wd[3:0];
                if (rise && m_cnt == 4'd0) m_err = 1'b1;
                if (iss && !(rise && m_cnt != 4'd0))      m_cnt = m_cnt + 4'd1;
                else if (!iss && rise && m_cnt != 4'd0)   m_cnt = m_cnt - 4'd1;
            end
        end
    endtask

    // Monitor: pop one expected item per cycle and compare it with the ports.
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (exp_q.size() > 0) begin
                logic [15:0] e;
                logic [15:0] g;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                g = {reg_rdata, pend_cnt, proto_err, strb_out, strb_ok, 1'b0};
                n_tests++;
                if (g !== e) begin
                    n_fail++;
                    $display("FAIL %s: rdata/cnt/err/strb/ok got %h/%0d/%b/%b/%b exp %h/%0d/%b/%b/%b",
                             t, g[15:8], g[7:4], g[3], g[2], g[1],
                             e[15:8], e[7:4], e[3], e[2], e[1]);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        // R1: state and read value out of hard reset
        step(0,0,0,0,0,0,1,7,8'h00,0,0,"R1");
        step(1,0,0,0,0,0,1,7,8'h00,0,0,"R1");
        // R8: normal-layout read and deselected reads
        step(1,0,0,0,0,0,1,7,8'h00,3'd5,5'd19,"R8");
        step(1,0,0,0,0,0,1,3,8'h00,3'd5,5'd19,"R8");
        step(1,0,0,0,0,0,0,7,8'h00,3'd5,5'd19,"R8");
        // R4: zero limit allows one byte outstanding
        step(1,0,0,1,0,0,0,0,8'h00,0,0,"R4");
        step(1,0,0,1,0,0,0,0,8'h00,0,0,"R4");
        step(1,0,0,1,0,0,0,0,8'h00,0,0,"R4");
        step(1,0,0,1,1,0,0,0,8'h00,0,0,"R5");
        // R11: strobe allowed the cycle after the count drops
        step(1,0,0,1,1,0,0,0,8'h00,0,0,"R11");
        step(1,0,0,0,0,0,0,0,8'h00,0,0,"R4");
        step(1,0,0,0,1,0,0,0,8'h00,0,0,"R5");
        step(1,0,0,0,0,0,0,0,8'h00,0,0,"R5");
        // R2: upper bits ignored, other address ignored
        step(1,0,0,0,0,1,0,7,8'hF3,0,0,"R2");
        step(1,0,0,0,0,1,0,2,8'h05,0,0,"R2");
        step(1,0,0,0,0,0,0,0,8'h00,0,0,"R2");
        step(1,0,0,0,0,0,0,0,8'h00,0,0,"R2");
        // R3: fill the window of three
        for (int i = 0; i < 5; i++) step(1,0,0,1,0,0,0,0,8'h00,0,0,"R3");
        // R5: simultaneous strobe and acknowledge
        step(1,0,0,0,1,0,0,0,8'h00,0,0,"R5");
        step(1,0,0,0,0,0,0,0,8'h00,0,0,"R5");
        step(1,0,0,1,1,0,0,0,8'h00,0,0,"R5");
        step(1,0,0,0,0,0,0,0,8'h00,0,0,"R5");
        // R6: shrink while in use, old window still governs
        step(1,0,0,0,0,1,0,7,8'h01,0,0,"R6");
        step(1,0,0,0,0,0,0,0,8'h00,0,0,"R6");
        step(1,0,0,1,0,0,0,0,8'h00,0,0,"R6");
        step(1,0,0,1,0,0,0,0,8'h00,0,0,"R6");
        for (int i = 0; i < 3; i++) begin
            step(1,0,0,0,1,0,0,0,8'h00,0,0,"R6");
            step(1,0,0,0,0,0,0,0,8'h00,0,0,"R6");
        end
        step(1,0,0,0,0,0,0,0,8'h00,0,0,"R6");
        for (int i = 0; i < 3; i++) step(1,0,0,1,0,0,0,0,8'h00,0,0,"R6");
        step(1,0,0,0,1,0,0,0,8'h00,0,0,"R6");
        step(1,0,0,0,0,0,0,0,8'h00,0,0,"R6");
        // R7: stray acknowledge sets a sticky error
        step(1,0,0,0,1,0,0,0,8'h00,0,0,"R7");
        step(1,0,0,0,0,0,0,0,8'h00,0,0,"R7");
        step(1,0,0,0,0,0,0,0,8'h00,0,0,"R7");
        // R9: test-mode open bit, window open then closed
        step(1,0,1,0,0,0,1,7,8'h00,3'd6,5'd7,"R9");
        step(1,0,0,1,0,0,0,0,8'h00,0,0,"R9");
        step(1,0,1,0,0,0,1,7,8'h00,3'd6,5'd7,"R9");
        step(1,0,0,0,0,0,1,7,8'h00,3'd6,5'd7,"R8");
        // R10: soft reset clears count, error and limit
        step(1,1,0,0,0,0,0,0,8'h00,0,0,"R10");
        step(1,0,0,1,0,0,0,0,8'h00,0,0,"R10");
        step(1,0,0,1,0,0,0,0,8'h00,0,0,"R10");
        step(1,0,0,1,0,0,0,0,8'h00,0,0,"R10");
        // R1: hard reset with a byte outstanding and an error set
        step(1,0,0,0,1,0,0,0,8'h00,0,0,"R1");
        step(1,0,0,0,0,0,0,0,8'h00,0,0,"R1");
        step(1,0,0,0,1,0,0,0,8'h00,0,0,"R1");
        step(1,0,0,0,0,1,0,7,8'h04,0,0,"R1");
        step(1,0,0,1,0,0,0,0,8'h00,0,0,"R1");
        step(0,0,0,0,0,0,0,0,8'h00,0,0,"R1");
        step(1,0,0,0,0,0,1,7,8'h00,0,0,"R1");
        step(1,0,0,1,0,0,0,0,8'h00,0,0,"R1");
        step(1,0,0,1,0,0,0,0,8'h00,0,0,"R1");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule